// File: doc/BRIEF.md
# Dual-Pattern Overlapping Sequence Counter

This block watches a one-bit serial line, taking one bit on every rising clock edge. It keeps an eight-bit running tally of how often either of two fixed four-bit patterns appears in the stream. Occurrences may share bits with earlier ones, and each completed occurrence adds one to the tally. The tally is the block's only result. It is meant to sit beside a serial data path, where a monitor or other logic reads the count directly.

The block has three parts. The first is a short history of recent bits, together with a fill level that shows how many valid bits have arrived since reset. The second compares that history against both patterns. The third is the wrapping counter. The two patterns begin with different bits, so at most one of them can complete on any edge.

Top module: `dual_seq_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the count becomes 0 after that edge. Reset is synchronous.
- R2: The arrival order 1,0,0,1 (first bit first) is recognised and adds one to the count.
- R3: The arrival order 0,1,0,1 (first bit first) is recognised and adds one to the count.
- R4: Overlapping occurrences are each counted. 1001001 gives 2, 010101 gives 2 and 100101 gives 2.
- R5: The count rises on the same edge that samples the fourth bit of a pattern, and it changes on no other edge.
- R6: From one edge to the next, the count either stays the same or grows by exactly one.
- R7: Past 255, the next match takes the count to 0. The count does not saturate.
- R8: After reset, a match needs four bits sampled after reset. Bits taken before reset never contribute to a match.
- R9: For the stream 11001010110100100110101010011101, fed first bit first, the count after every edge equals a sliding four-bit window reference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data bit, sampled each edge |
| count | output | 8 | Number of pattern completions, modulo 256 |

## Verification
Short isolated strings check each pattern alone, a self-overlapping chain of each, and a chain in which one pattern's tail begins the other. Together these separate a detector that restarts after a hit from one that keeps its history. A string of all ones followed by all zeros must leave the count at zero, which exposes false matches. A partial pattern is fed, reset is applied, and the pattern is then finished; this shows whether history is cleared at reset. A long run of back-to-back overlapping hits drives the count across 255 and exposes saturation. The 32-bit stream is then compared edge by edge against a windowed model.

// File: rtl/seqcnt_pkg.sv
package seqcnt_pkg;
    localparam int PAT_W   = 4;
    localparam int NUM_PAT = 2;
    localparam int FILL_W  = $clog2(PAT_W);

    typedef logic [PAT_W-1:0] pat_t;

    // index 0: 1,0,0,1   index 1: 0,1,0,1   (oldest bit at MSB)
    localparam logic [NUM_PAT*PAT_W-1:0] PATTERNS = {4'b0101, 4'b1001};

    typedef struct packed {
        logic [PAT_W-2:0] bits;   // previous PAT_W-1 bits, newest at LSB
        logic [FILL_W-1:0] fill;  // valid bits held, saturates at PAT_W-1
    } hist_t;

    function automatic pat_t pattern_at(input int idx);
        return PATTERNS[idx*PAT_W +: PAT_W];
    endfunction

    function automatic logic [FILL_W-1:0] fill_next(input logic [FILL_W-1:0] f);
        return (f == FILL_W'(PAT_W-1)) ? f : f + 1'b1;
    endfunction
endpackage

// File: rtl/seq_history.sv
module seq_history
    import seqcnt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    output pat_t window,
    output logic primed
);
    hist_t hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else begin
            hist_q.bits <= {hist_q.bits[PAT_W-3:0], din};
            hist_q.fill <= fill_next(hist_q.fill);
        end
    end

    // window includes the bit being sampled on this edge
    assign window = {hist_q.bits, din};
    assign primed = (hist_q.fill == FILL_W'(PAT_W-1));
endmodule

// File: rtl/seq_matcher.sv
module seq_matcher
    import seqcnt_pkg::*;
(
    input  pat_t window,
    input  logic primed,
    output logic hit
);
    logic [NUM_PAT-1:0] eq;

    for (genvar p = 0; p < NUM_PAT; p++) begin : g_cmp
        assign eq[p] = (window == pattern_at(p));
    end

    assign hit = primed && (|eq);
endmodule

// File: rtl/seq_accum.sv
module seq_accum #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)      count <= '0;
        else if (inc) count <= count + 1'b1;
    end
endmodule

// File: rtl/dual_seq_counter.sv
module dual_seq_counter
    import seqcnt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    output logic [CNT_W-1:0] count
);
    pat_t window;
    logic primed;
    logic hit;

    seq_history u_hist (
        .clk    (clk),
        .rst    (rst),
        .din    (din),
        .window (window),
        .primed (primed)
    );

    seq_matcher u_match (
        .window (window),
        .primed (primed),
        .hit    (hit)
    );

    seq_accum #(.CNT_W(CNT_W)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .inc   (hit),
        .count (count)
    );
endmodule

// File: rtl/seq_counter_chk.sv
module seq_counter_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             din,
    input logic [CNT_W-1:0] count
);
    logic [2:0] c_hist;
    logic [2:0] c_seen;
    logic       c_full;
    logic       c_match;

    always_ff @(posedge clk) begin
        if (rst) begin
            c_hist <= '0;
            c_seen <= '0;
        end else begin
            c_hist <= {c_hist[1:0], din};
            if (c_seen != 3'd4) c_seen <= c_seen + 1'b1;
        end
    end

    assign c_full  = (c_seen >= 3'd3);
    assign c_match = c_full && (({c_hist, din} == 4'b1001) || ({c_hist, din} == 4'b0101));

    // R1 / R8: no count during the first three sampled bits after reset
    assert_fresh_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (c_seen < 3'd3) |=> (count == '0));

    // R2
    assert_first_pat_R2: assert property (@(posedge clk) disable iff (rst)
        (c_full && {c_hist, din} == 4'b1001) |=> (count == CNT_W'($past(count) + 1'b1)));

    // R3
    assert_second_pat_R3: assert property (@(posedge clk) disable iff (rst)
        (c_full && {c_hist, din} == 4'b0101) |=> (count == CNT_W'($past(count) + 1'b1)));

    // R5
    assert_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !c_match |=> $stable(count));

    // R6
    assert_single_step_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((count == $past(count)) || (count == CNT_W'($past(count) + 1'b1))));
endmodule

bind dual_seq_counter seq_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .din   (din),
    .count (count)
);

// File: tb/dual_seq_counter_tb.sv
module dual_seq_counter_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din = 1'b0;
    logic [7:0] count;

    int n_vec = 0;
    int n_bad = 0;

    logic [2:0] m_hist;
    int         m_seen;
    logic [7:0] m_cnt;

    // {length, bits (first bit at position length-1), expected count}
    localparam int NV = 8;
    localparam logic [47:0] VECS [NV] = '{
        {8'd4, 32'b1001,     8'd1},   // R2
        {8'd4, 32'b0101,     8'd1},   // R3
        {8'd7, 32'b1001001,  8'd2},   // R4
        {8'd6, 32'b010101,   8'd2},   // R4
        {8'd6, 32'b100101,   8'd2},   // R4 cross
        {8'd8, 32'b11110000, 8'd0},   // R5 no false hit
        {8'd3, 32'b100,      8'd0},   // R8 short
        {8'd8, 32'b10010101, 8'd3}    // R4 chained
    };

    localparam logic [31:0] STREAM = 32'b11001010110100100110101010011101;

    dual_seq_counter u_dut (
        .clk   (clk),
        .rst   (rst),
        .din   (din),
        .count (count)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input logic [7:0] exp);
        n_vec++;
        if (count !== exp) begin
            n_bad++;
            $display("FAIL %s: count=%0d expected=%0d", tag, count, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        m_hist = '0;
        m_seen = 0;
        m_cnt  = '0;
        check("R1 reset", 8'd0);
    endtask

    task automatic send_bit(input logic b, input string tag);
        din = b;
        @(posedge clk);
        #1;
        if (m_seen >= 3 && ({m_hist, b} == 4'b1001 || {m_hist, b} == 4'b0101))
            m_cnt = m_cnt + 8'd1;
        m_hist = {m_hist[1:0], b};
        if (m_seen < 4) m_seen++;
        check(tag, m_cnt);
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: count=%0d expected=finished run", count);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        do_reset();

        // table of short vectors, R5 timing checked at every bit
        for (int v = 0; v < NV; v++) begin
            int len;
            len = int'(VECS[v][47:40]);
            do_reset();
            for (int i = len - 1; i >= 0; i--) send_bit(VECS[v][8 + i], "R5 per-edge");
            check("R4 table final", VECS[v][7:0]);
        end

        // R8: partial pattern before reset must not complete afterwards
        do_reset();
        send_bit(1'b0, "R8 pre");
        send_bit(1'b1, "R8 pre");
        send_bit(1'b0, "R8 pre");
        do_reset();
        send_bit(1'b1, "R8 post");
        check("R8 no stale match", 8'd0);
        send_bit(1'b0, "R8 post");
        send_bit(1'b0, "R8 post");
        check("R8 three bits", 8'd0);
        send_bit(1'b1, "R8 post");
        check("R8 fourth bit counts", 8'd1);

        // R1: reset clears a nonzero count
        do_reset();
        check("R1 clear", 8'd0);

        // R9 / R6: the given stream, compared every edge
        for (int i = 31; i >= 0; i--) send_bit(STREAM[i], "R9 R6 stream");

        // R7: wrap past 255
        do_reset();
        send_bit(1'b1, "R7");
        send_bit(1'b0, "R7");
        send_bit(1'b0, "R7");
        send_bit(1'b1, "R7");
        for (int k = 0; k < 254; k++) begin
            send_bit(1'b0, "R7");
            send_bit(1'b0, "R7");
            send_bit(1'b1, "R7");
        end
        check("R7 at 255", 8'd255);
        send_bit(1'b0, "R7");
        send_bit(1'b0, "R7");
        send_bit(1'b1, "R7");
        check("R7 wrapped", 8'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule